// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether one memory access may proceed once a segment has been matched and a page table entry fetched. It takes the access kind (load, store or instruction fetch), the privilege state, the two translation enables, the matched segment's attributes and the entry's protection fields. It folds the entry's three-bit protection code, picked through a privilege-selected key, together with a two-bit-per-key authority mask, and produces a read/write/execute permission set. A denied access gets a fault class and a 32-bit status word. Accesses with translation off and accesses that missed every segment are resolved here as well.

Each request is captured in an input register when `req_valid` is high. The verdict is formed combinationally from that register and appears on the outputs in the following cycle, marked by `rsp_valid`. Table walking, segment storage and real-address formation for translated pages belong to neighbouring blocks.

Top module: `pacc_checker`

## Requirements
- R1: After reset, and in every cycle where `rsp_valid` is low, all response outputs are zero.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and the response belongs to the request captured at that edge.
- R3: Translation is off when the access is a fetch (`req_acc`=2) with `xlate_inst_en` low, or a load (0) or store (1) with `xlate_data_en` low. Such an access is allowed with `perm`=3'b111 (bit 0 read, bit 1 write, bit 2 execute), no fault, and `real_addr` equal to `req_ea` with its top 4 bits cleared. `real_addr` is zero in every other case. `req_acc`=3 is treated as a load.
- R4: The protection key is `seg_key_user` when `req_user` is high, and `seg_key_sup` otherwise.
- R5: The protection code is {`pte_pp0`, `pte_pp`}. For key 0, codes 0 to 2 grant read and write, codes 3 and 6 grant read only, and codes 4, 5 and 7 grant nothing. For key 1, codes 1 and 3 grant read only, code 2 grants read and write, and all other codes grant nothing.
- R6: Execute is withheld when `pte_nx`, `pte_guard` or `seg_nx` is set.
- R7: With `key_mask_en` high, the mask pair for `pte_key` sits at bit offset 2*(31-key). Its upper bit grants write and its lower bit grants read, and execute is always granted by the mask. With `key_mask_en` low, the mask grants everything.
- R8: On a translated access that reaches the permission stage, `perm` is the AND of the protection-code result and the mask result. The access is allowed exactly when `perm` holds the bit it needs, and `allowed` is high exactly when `fault_kind` is 0.
- R9: A translated access with `seg_hit` low gives `fault_kind` 1 for a fetch and 2 for a load or store, with status 0 and `perm` 0.
- R10: A fetch in a segment with `seg_nx` set gives fault kind 3 with status 32'h1000_0000. This outcome takes precedence over a missing entry.
- R11: With `pte_found` low, a fetch gives kind 3 with status 32'h4000_0000. A load gives kind 4 with 32'h4000_0000, and a store gives kind 4 with 32'h4200_0000.
- R12: A permission failure on a fetch gives kind 3 with status 32'h0800_0000. On a load or store it gives kind 4, with the status ORed from 32'h0800_0000 (protection code denied), 32'h0200_0000 (store) and 32'h0020_0000 (mask denied).
- R13: `fault_addr_valid` is high, and `fault_addr` equals `req_ea`, only for data faults (kinds 2 and 4). Otherwise `fault_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Capture a request this cycle |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| req_user | input | 1 | Processor in user state |
| xlate_inst_en | input | 1 | Instruction translation enabled |
| xlate_data_en | input | 1 | Data translation enabled |
| req_ea | input | 64 | Effective address |
| seg_hit | input | 1 | A segment matched |
| seg_key_user | input | 1 | Segment key used in user state |
| seg_key_sup | input | 1 | Segment key used in supervisor state |
| seg_nx | input | 1 | Segment forbids execution |
| pte_found | input | 1 | Page table entry located |
| pte_pp | input | 2 | Low two bits of protection code |
| pte_pp0 | input | 1 | Top bit of protection code |
| pte_nx | input | 1 | Entry forbids execution |
| pte_guard | input | 1 | Entry is guarded |
| pte_key | input | 5 | Entry's authority key |
| key_mask | input | 64 | Authority mask, two bits per key |
| key_mask_en | input | 1 | Authority mask check enabled |
| rsp_valid | output | 1 | Response valid |
| allowed | output | 1 | Access permitted |
| fault_kind | output | 3 | 0 none, 1 instr segment, 2 data segment, 3 instr storage, 4 data storage |
| status_code | output | 32 | Fault status word |
| fault_addr_valid | output | 1 | Faulting address reported |
| fault_addr | output | 64 | Faulting effective address |
| perm | output | 3 | Effective permission {x,w,r} |
| real_addr | output | 64 | Real address when translation is off |

## Verification
The internal state is just the captured request, so any corruption shows up on the response in the very next cycle. A wrong key pick, a wrong code-table row or a misplaced mask pair changes `perm` and usually `allowed` right away. A swapped precedence or a dropped status bit shows up as the wrong fault kind or status word. The bench therefore compares every output against a behavioural model on every clock. It sweeps every code under both keys, both privilege states, keys at both ends of the mask and one in the middle, and each fault path for each access kind.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    FK_NONE = 3'd0,
    FK_ISEG = 3'd1,
    FK_DSEG = 3'd2,
    FK_ISTO = 3'd3,
    FK_DSTO = 3'd4
  } fault_e;

  localparam int unsigned STATUS_W = 32;
  localparam int unsigned PERM_R   = 0;
  localparam int unsigned PERM_W   = 1;
  localparam int unsigned PERM_X   = 2;

  localparam logic [STATUS_W-1:0] ST_SEG_NOEXEC = 32'h1000_0000;
  localparam logic [STATUS_W-1:0] ST_NO_ENTRY   = 32'h4000_0000;
  localparam logic [STATUS_W-1:0] ST_PROT_DENY  = 32'h0800_0000;
  localparam logic [STATUS_W-1:0] ST_IS_STORE   = 32'h0200_0000;
  localparam logic [STATUS_W-1:0] ST_MASK_DENY  = 32'h0020_0000;

endpackage

// File: rtl/pacc_pp_decode.sv
module pacc_pp_decode
  import pacc_pkg::*;
(
  input  logic       key,
  input  logic [1:0] pp_lo,
  input  logic       pp_hi,
  input  logic       pte_nx,
  input  logic       pte_guard,
  input  logic       seg_nx,
  output logic [2:0] perm
);

  logic [2:0] code;
  logic       rd;
  logic       wr;

  always_comb begin
    code = {pp_hi, pp_lo};
    rd   = 1'b0;
    wr   = 1'b0;
    if (!key) begin
      case (code)
        3'd0, 3'd1, 3'd2: begin rd = 1'b1; wr = 1'b1; end
        3'd3, 3'd6:       begin rd = 1'b1; wr = 1'b0; end
        default:          begin rd = 1'b0; wr = 1'b0; end
      endcase
    end else begin
      case (code)
        3'd1, 3'd3: begin rd = 1'b1; wr = 1'b0; end
        3'd2:       begin rd = 1'b1; wr = 1'b1; end
        default:    begin rd = 1'b0; wr = 1'b0; end
      endcase
    end
    perm         = '0;
    perm[PERM_R] = rd;
    perm[PERM_W] = wr;
    perm[PERM_X] = ~(pte_nx | pte_guard | seg_nx);
  end

endmodule

// File: rtl/pacc_mask_decode.sv
module pacc_mask_decode
  import pacc_pkg::*;
#(
  parameter int unsigned KEY_W = 5
) (
  input  logic [KEY_W-1:0]          key,
  input  logic [2*(2**KEY_W)-1:0]   mask,
  input  logic                      enable,
  output logic [2:0]                perm
);

  localparam int unsigned NKEYS = 2 ** KEY_W;

  logic [1:0] pair [NKEYS];

  // key k owns the pair counted from the top of the register
  for (genvar k = 0; k < NKEYS; k++) begin : g_pair
    assign pair[k] = mask[2*(NKEYS-1-k) +: 2];
  end

  logic [1:0] sel;

  always_comb begin
    sel  = pair[key];
    perm = 3'b111;
    if (enable) begin
      perm[PERM_R] = sel[0];
      perm[PERM_W] = sel[1];
    end
  end

endmodule

// File: rtl/pacc_fault_gen.sv
module pacc_fault_gen
  import pacc_pkg::*;
(
  input  logic [1:0]          acc,
  input  logic                inst_en,
  input  logic                data_en,
  input  logic                seg_hit,
  input  logic                seg_nx,
  input  logic                pte_found,
  input  logic [2:0]          perm_pp,
  input  logic [2:0]          perm_mask,
  output logic                real_mode,
  output logic                allowed,
  output fault_e              kind,
  output logic [STATUS_W-1:0] status,
  output logic                addr_valid,
  output logic [2:0]          perm
);

  logic       is_fetch;
  logic       is_store;
  logic [2:0] need;
  logic [2:0] eff;
  logic       pp_deny;
  logic       mask_deny;

  always_comb begin
    is_fetch  = (acc == ACC_FETCH);
    is_store  = (acc == ACC_STORE);
    need      = '0;
    if (is_fetch)      need[PERM_X] = 1'b1;
    else if (is_store) need[PERM_W] = 1'b1;
    else               need[PERM_R] = 1'b1;
    eff       = perm_pp & perm_mask;
    pp_deny   = |(need & ~perm_pp);
    mask_deny = |(need & ~perm_mask);
    real_mode = is_fetch ? ~inst_en : ~data_en;

    allowed    = 1'b0;
    kind       = FK_NONE;
    status     = '0;
    addr_valid = 1'b0;
    perm       = '0;

    if (real_mode) begin
      allowed = 1'b1;
      perm    = 3'b111;
    end else if (!seg_hit) begin
      kind       = is_fetch ? FK_ISEG : FK_DSEG;
      addr_valid = ~is_fetch;
    end else if (is_fetch && seg_nx) begin
      kind   = FK_ISTO;
      status = ST_SEG_NOEXEC;
    end else if (!pte_found) begin
      kind       = is_fetch ? FK_ISTO : FK_DSTO;
      status     = ST_NO_ENTRY | ((is_store) ? ST_IS_STORE : '0);
      addr_valid = ~is_fetch;
    end else begin
      perm = eff;
      if (!(pp_deny || mask_deny)) begin
        allowed = 1'b1;
      end else if (is_fetch) begin
        kind   = FK_ISTO;
        status = ST_PROT_DENY;
      end else begin
        kind       = FK_DSTO;
        addr_valid = 1'b1;
        status     = (pp_deny   ? ST_PROT_DENY : '0)
                   | (is_store  ? ST_IS_STORE  : '0)
                   | (mask_deny ? ST_MASK_DENY : '0);
      end
    end
  end

endmodule

// File: rtl/pacc_checker.sv
module pacc_checker
  import pacc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 64,
  parameter int unsigned KEY_W       = 5,
  parameter int unsigned REAL_IGNORE = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [1:0]                req_acc,
  input  logic                      req_user,
  input  logic                      xlate_inst_en,
  input  logic                      xlate_data_en,
  input  logic [ADDR_W-1:0]         req_ea,
  input  logic                      seg_hit,
  input  logic                      seg_key_user,
  input  logic                      seg_key_sup,
  input  logic                      seg_nx,
  input  logic                      pte_found,
  input  logic [1:0]                pte_pp,
  input  logic                      pte_pp0,
  input  logic                      pte_nx,
  input  logic                      pte_guard,
  input  logic [KEY_W-1:0]          pte_key,
  input  logic [2*(2**KEY_W)-1:0]   key_mask,
  input  logic                      key_mask_en,
  output logic                      rsp_valid,
  output logic                      allowed,
  output logic [2:0]                fault_kind,
  output logic [STATUS_W-1:0]       status_code,
  output logic                      fault_addr_valid,
  output logic [ADDR_W-1:0]         fault_addr,
  output logic [2:0]                perm,
  output logic [ADDR_W-1:0]         real_addr
);

  localparam int unsigned MASK_W = 2 * (2 ** KEY_W);
  localparam int unsigned KEEP_W = ADDR_W - REAL_IGNORE;

  typedef struct packed {
    logic [1:0]        acc;
    logic              user;
    logic              inst_en;
    logic              data_en;
    logic [ADDR_W-1:0] ea;
    logic              seg_hit;
    logic              key_user;
    logic              key_sup;
    logic              seg_nx;
    logic              found;
    logic [1:0]        pp;
    logic              pp0;
    logic              nx;
    logic              guard;
    logic [KEY_W-1:0]  key;
    logic [MASK_W-1:0] mask;
    logic              mask_en;
  } req_t;

  req_t req_d, req_q;
  logic vld_d, vld_q;

  // next-state
  always_comb begin
    vld_d = req_valid;
    req_d = req_q;
    if (req_valid) begin
      req_d.acc      = req_acc;
      req_d.user     = req_user;
      req_d.inst_en  = xlate_inst_en;
      req_d.data_en  = xlate_data_en;
      req_d.ea       = req_ea;
      req_d.seg_hit  = seg_hit;
      req_d.key_user = seg_key_user;
      req_d.key_sup  = seg_key_sup;
      req_d.seg_nx   = seg_nx;
      req_d.found    = pte_found;
      req_d.pp       = pte_pp;
      req_d.pp0      = pte_pp0;
      req_d.nx       = pte_nx;
      req_d.guard    = pte_guard;
      req_d.key      = pte_key;
      req_d.mask     = key_mask;
      req_d.mask_en  = key_mask_en;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      req_q <= '0;
    end else begin
      vld_q <= vld_d;
      req_q <= req_d;
    end
  end

  logic       sel_key;
  logic [2:0] perm_pp;
  logic [2:0] perm_mask;

  assign sel_key = req_q.user ? req_q.key_user : req_q.key_sup;

  pacc_pp_decode u_pp (
    .key       (sel_key),
    .pp_lo     (req_q.pp),
    .pp_hi     (req_q.pp0),
    .pte_nx    (req_q.nx),
    .pte_guard (req_q.guard),
    .seg_nx    (req_q.seg_nx),
    .perm      (perm_pp)
  );

  pacc_mask_decode #(.KEY_W(KEY_W)) u_mask (
    .key    (req_q.key),
    .mask   (req_q.mask),
    .enable (req_q.mask_en),
    .perm   (perm_mask)
  );

  logic                real_mode;
  logic                fg_allowed;
  fault_e              fg_kind;
  logic [STATUS_W-1:0] fg_status;
  logic                fg_addr_valid;
  logic [2:0]          fg_perm;

  pacc_fault_gen u_fault (
    .acc        (req_q.acc),
    .inst_en    (req_q.inst_en),
    .data_en    (req_q.data_en),
    .seg_hit    (req_q.seg_hit),
    .seg_nx     (req_q.seg_nx),
    .pte_found  (req_q.found),
    .perm_pp    (perm_pp),
    .perm_mask  (perm_mask),
    .real_mode  (real_mode),
    .allowed    (fg_allowed),
    .kind       (fg_kind),
    .status     (fg_status),
    .addr_valid (fg_addr_valid),
    .perm       (fg_perm)
  );

  always_comb begin
    rsp_valid        = vld_q;
    allowed          = vld_q & fg_allowed;
    fault_kind       = vld_q ? fg_kind : FK_NONE;
    status_code      = vld_q ? fg_status : '0;
    fault_addr_valid = vld_q & fg_addr_valid;
    fault_addr       = (vld_q && fg_addr_valid) ? req_q.ea : '0;
    perm             = vld_q ? fg_perm : '0;
    real_addr        = (vld_q && real_mode)
                     ? {{REAL_IGNORE{1'b0}}, req_q.ea[KEEP_W-1:0]} : '0;
  end

endmodule

// File: rtl/pacc_checker_sva.sv
module pacc_checker_sva
  import pacc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 64,
  parameter int unsigned REAL_IGNORE = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [1:0]          req_acc,
  input logic                xlate_inst_en,
  input logic                xlate_data_en,
  input logic                rsp_valid,
  input logic                allowed,
  input logic [2:0]          fault_kind,
  input logic [STATUS_W-1:0] status_code,
  input logic                fault_addr_valid,
  input logic [2:0]          perm,
  input logic [ADDR_W-1:0]   real_addr
);

  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  logic real_req;
  assign real_req = req_valid &&
                    ((req_acc == ACC_FETCH) ? !xlate_inst_en : !xlate_data_en);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!allowed && fault_kind == 3'd0 && status_code == '0
                    && !fault_addr_valid && perm == 3'd0));

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (rsp_valid == $past(req_valid)));

  p_real_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(real_req)) |->
      (allowed && perm == 3'b111 && real_addr[ADDR_W-1 -: REAL_IGNORE] == '0));

  p_allow_nofault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (allowed == (fault_kind == FK_NONE)));

  p_seg_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (fault_kind == FK_ISEG || fault_kind == FK_DSEG))
      |-> (status_code == '0 && perm == 3'd0));

  p_ifault_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && fault_kind == FK_ISTO) |-> ($countones(status_code) == 1));

  p_faddr_data_r13: assert property (@(posedge clk) disable iff (!rst_n)
    fault_addr_valid |-> (fault_kind == FK_DSEG || fault_kind == FK_DSTO));

endmodule

bind pacc_checker pacc_checker_sva #(
  .ADDR_W      (ADDR_W),
  .REAL_IGNORE (REAL_IGNORE)
) u_sva (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_valid        (req_valid),
  .req_acc          (req_acc),
  .xlate_inst_en    (xlate_inst_en),
  .xlate_data_en    (xlate_data_en),
  .rsp_valid        (rsp_valid),
  .allowed          (allowed),
  .fault_kind       (fault_kind),
  .status_code      (status_code),
  .fault_addr_valid (fault_addr_valid),
  .perm             (perm),
  .real_addr        (real_addr)
);

// File: tb/pacc_checker_bench.sv
module pacc_checker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic        xlate_inst_en = 1'b1;
  logic        xlate_data_en = 1'b1;
  logic [63:0] req_ea = '0;
  logic        seg_hit = 1'b1;
  logic        seg_key_user = 1'b0;
  logic        seg_key_sup = 1'b0;
  logic        seg_nx = 1'b0;
  logic        pte_found = 1'b1;
  logic [1:0]  pte_pp = '0;
  logic        pte_pp0 = 1'b0;
  logic        pte_nx = 1'b0;
  logic        pte_guard = 1'b0;
  logic [4:0]  pte_key = '0;
  logic [63:0] key_mask = '0;
  logic        key_mask_en = 1'b0;

  logic        rsp_valid;
  logic        allowed;
  logic [2:0]  fault_kind;
  logic [31:0] status_code;
  logic        fault_addr_valid;
  logic [63:0] fault_addr;
  logic [2:0]  perm;
  logic [63:0] real_addr;

  pacc_checker u_pacc_checker (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_acc (req_acc),
    .req_user (req_user), .xlate_inst_en (xlate_inst_en),
    .xlate_data_en (xlate_data_en), .req_ea (req_ea), .seg_hit (seg_hit),
    .seg_key_user (seg_key_user), .seg_key_sup (seg_key_sup),
    .seg_nx (seg_nx), .pte_found (pte_found), .pte_pp (pte_pp),
    .pte_pp0 (pte_pp0), .pte_nx (pte_nx), .pte_guard (pte_guard),
    .pte_key (pte_key), .key_mask (key_mask), .key_mask_en (key_mask_en),
    .rsp_valid (rsp_valid), .allowed (allowed), .fault_kind (fault_kind),
    .status_code (status_code), .fault_addr_valid (fault_addr_valid),
    .fault_addr (fault_addr), .perm (perm), .real_addr (real_addr)
  );

  always #5 clk = ~clk;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  logic        e_valid, e_allowed, e_fav;
  logic [2:0]  e_kind, e_perm;
  logic [31:0] e_status;
  logic [63:0] e_faddr, e_raddr;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural model of the requirements
  task automatic model(input bit v);
    int  code, k, need;
    bit  fetch, store, r, w, x, ar, aw;
    bit  pp_bad, mk_bad;
    int  have;
    e_valid = v; e_allowed = 0; e_fav = 0; e_kind = 0; e_perm = 0;
    e_status = 0; e_faddr = 0; e_raddr = 0;
    if (!v) return;
    fetch = (req_acc == 2);
    store = (req_acc == 1);
    need  = fetch ? 4 : (store ? 2 : 1);
    if (fetch ? !xlate_inst_en : !xlate_data_en) begin
      e_allowed = 1; e_perm = 7;
      e_raddr = req_ea & 64'h0FFF_FFFF_FFFF_FFFF;
      return;
    end
    if (!seg_hit) begin
      e_kind = fetch ? 1 : 2;
      e_fav  = !fetch;
    end else if (fetch && seg_nx) begin
      e_kind = 3; e_status = 32'h1000_0000;
    end else if (!pte_found) begin
      e_kind = fetch ? 3 : 4;
      e_status = store ? 32'h4200_0000 : 32'h4000_0000;
      e_fav = !fetch;
    end else begin
      code = int'(pte_pp0) * 4 + int'(pte_pp);
      k    = req_user ? int'(seg_key_user) : int'(seg_key_sup);
      if (k == 0) begin r = (code <= 3) || (code == 6); w = (code <= 2); end
      else begin r = (code >= 1 && code <= 3); w = (code == 2); end
      x = !(pte_nx || pte_guard || seg_nx);
      if (key_mask_en) begin
        ar = key_mask[2*(31-int'(pte_key))];
        aw = key_mask[2*(31-int'(pte_key))+1];
      end else begin ar = 1; aw = 1; end
      have   = (int'(x) << 2) | (int'(w & aw) << 1) | int'(r & ar);
      e_perm = 3'(have);
      pp_bad = ((need & ~((int'(x) << 2) | (int'(w) << 1) | int'(r))) != 0);
      mk_bad = ((need & ~(4 | (int'(aw) << 1) | int'(ar))) != 0);
      if ((need & have) != 0) e_allowed = 1;
      else if (fetch) begin e_kind = 3; e_status = 32'h0800_0000; end
      else begin
        e_kind = 4; e_fav = 1;
        if (pp_bad) e_status |= 32'h0800_0000;
        if (store)  e_status |= 32'h0200_0000;
        if (mk_bad) e_status |= 32'h0020_0000;
      end
    end
    if (e_fav) e_faddr = req_ea;
  endtask

  task automatic compare(input string tag);
    chk(tag, "rsp_valid", 64'(rsp_valid), 64'(e_valid));
    chk(tag, "allowed", 64'(allowed), 64'(e_allowed));
    chk(tag, "fault_kind", 64'(fault_kind), 64'(e_kind));
    chk(tag, "status_code", 64'(status_code), 64'(e_status));
    chk(tag, "fault_addr_valid", 64'(fault_addr_valid), 64'(e_fav));
    chk(tag, "fault_addr", fault_addr, e_faddr);
    chk(tag, "perm", 64'(perm), 64'(e_perm));
    chk(tag, "real_addr", real_addr, e_raddr);
  endtask

  // inputs are set at a falling edge; outputs are read at the next one
  task automatic step(input string tag, input bit v);
    req_valid = v;
    model(v);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic plain();
    xlate_inst_en = 1; xlate_data_en = 1; seg_hit = 1; seg_nx = 0;
    pte_found = 1; pte_nx = 0; pte_guard = 0; key_mask_en = 0;
    req_user = 0; seg_key_user = 0; seg_key_sup = 0;
    pte_pp = 2'd2; pte_pp0 = 0; pte_key = 0; key_mask = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    e_valid = 0; e_allowed = 0; e_fav = 0; e_kind = 0; e_perm = 0;
    e_status = 0; e_faddr = 0; e_raddr = 0;
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    step("R1", 0);

    // R3 translation off, both kinds
    plain();
    req_ea = 64'hFEDC_BA98_7654_3210;
    req_acc = 0; xlate_data_en = 0; xlate_inst_en = 1; seg_hit = 0;
    step("R3", 1);
    req_acc = 1; step("R3", 1);
    req_acc = 3; step("R3", 1);
    req_acc = 2; xlate_inst_en = 0; xlate_data_en = 1; step("R3", 1);
    // fetch with only data translation off is translated: segment miss
    xlate_inst_en = 1; xlate_data_en = 0; step("R9", 1);

    // R9 / R13 segment misses
    plain(); seg_hit = 0; req_ea = 64'h0000_1234_5678_9ABC;
    req_acc = 0; step("R9", 1);
    req_acc = 1; step("R13", 1);
    req_acc = 2; step("R9", 1);

    // R2 idle gap then back-to-back
    step("R2", 0);
    step("R2", 0);

    // R10 segment no-execute beats missing entry
    plain(); seg_nx = 1; req_acc = 2; pte_found = 0; step("R10", 1);
    pte_found = 1; step("R10", 1);
    req_acc = 0; step("R6", 1);

    // R11 missing entry
    plain(); pte_found = 0; req_ea = 64'h8000_0000_0000_0040;
    req_acc = 0; step("R11", 1);
    req_acc = 1; step("R11", 1);
    req_acc = 2; step("R11", 1);

    // R4 / R5 full code table, both keys via privilege selection
    plain();
    for (int u = 0; u < 2; u++) begin
      for (int c = 0; c < 8; c++) begin
        for (int a = 0; a < 2; a++) begin
          req_user = u[0]; seg_key_user = 1; seg_key_sup = 0;
          pte_pp = c[1:0]; pte_pp0 = c[2]; req_acc = a[1:0];
          step(u == 0 ? "R5" : "R4", 1);
          seg_key_user = 0; seg_key_sup = 1;
          step(u == 0 ? "R4" : "R5", 1);
        end
      end
    end

    // R6 execute denial by entry bits
    plain(); req_acc = 2;
    step("R6", 1);
    pte_nx = 1; step("R6", 1);
    pte_nx = 0; pte_guard = 1; step("R12", 1);
    pte_guard = 0;

    // R7 mask placement at both ends and the middle
    plain(); key_mask_en = 1;
    for (int kk = 0; kk < 3; kk++) begin
      pte_key = (kk == 0) ? 5'd0 : ((kk == 1) ? 5'd31 : 5'd17);
      for (int m = 0; m < 4; m++) begin
        key_mask = '0;
        key_mask[2*(31-int'(pte_key)) +: 2] = m[1:0];
        for (int a = 0; a < 3; a++) begin
          req_acc = a[1:0];
          step("R7", 1);
        end
      end
      // neighbouring pairs set, own pair clear
      key_mask = ~64'd0;
      key_mask[2*(31-int'(pte_key)) +: 2] = 2'b00;
      req_acc = 0; step("R7", 1);
    end

    // R8 / R12 combined causes
    plain(); key_mask_en = 1; pte_key = 5'd9;
    key_mask = '0; key_mask[2*(31-9)] = 1'b1;          // read only by mask
    req_acc = 1; step("R8", 1);                      // mask denies store
    pte_pp = 2'd3; step("R12", 1);                   // both deny store
    req_acc = 0; step("R8", 1);                      // read allowed
    key_mask = '0; step("R12", 1);                   // mask denies read
    pte_pp = 2'd2; seg_key_sup = 1; pte_pp0 = 1;     // key1 code6: nothing
    key_mask_en = 0; step("R12", 1);

    // R2 consecutive requests then idle
    plain(); req_acc = 0; step("R2", 1);
    req_acc = 1; step("R2", 1);
    step("R2", 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule